// File: doc/BRIEF.md
# E1 Reduced-Slot Transmit Frame Multiplexer

This block assembles the serial transmit bitstream of one 2.048 Mbit/s E1 link toward a remote radio base station. Only a few of the 32 eight-bit slots carry traffic. It counts bits, slots and frames on the bit clock. For each slot it picks the byte that slot should carry and shifts it out most significant bit first. The bytes are a frame alignment or non-alignment word, eight voice channel bytes, one common-channel signalling byte, a multiframe marker, or idle fill.

The multiframe marker marks one frame out of every `MF_FRAMES` frames. The default of 2560 frames gives a 320 ms period at the 8 kHz frame rate. The block drives a frame strobe and a multiframe strobe so that the logic feeding the voice and signalling bytes can align to the frame. Each source byte is captured on the clock edge that opens its slot, so the upstream side may change its inputs freely while that slot is being sent.

Top module: `e1_slot_mux`

## Requirements
- R1: While reset is held, and in the first bit period after release, `frame_start` and `mframe_start` are 1. `tx_bit` carries the first bit of the alignment word, so the first frame is an even frame and a multiframe-marker frame.
- R2: A frame is 32 slots of 8 bit periods. `frame_start` is 1 only during bit 0 of slot 0, which makes it a one-cycle pulse every 256 clocks.
- R3: Slot 0 sends 0x9B (alignment, 1001_1011) in even frames and 0xDF (non-alignment, bit 2 counted from the MSB as bit 1 set) in odd frames. The parity alternates on every frame, independently of the multiframe count.
- R4: Slot k+1 (k = 0..7) sends voice byte k, taken from `voice_bytes[8k+7:8k]`.
- R5: Slot 16 sends `sig_byte`.
- R6: Slot 17 sends 0xFF in a multiframe-marker frame and 0x00 in every other frame.
- R7: Marker frames recur every `MF_FRAMES` frames. `mframe_start` is 1 only during bit 0 of slot 0 of a marker frame.
- R8: Slots 9 to 15 and 18 to 31 send 0xFF.
- R9: Each byte is sent most significant bit first, one bit per clock.
- R10: Voice and signalling inputs are sampled at the clock edge that begins their slot. Later changes during that slot do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| voice_bytes | input | 8*NUM_VOICE | Voice channel bytes, channel k in bits 8k+7:8k |
| sig_byte | input | 8 | Common-channel signalling byte |
| tx_bit | output | 1 | Serial transmit data |
| frame_start | output | 1 | High during the first bit of each frame |
| mframe_start | output | 1 | High during the first bit of each multiframe-marker frame |

## Verification
The voice and signalling inputs are given new random values on every clock. A bit-exact match therefore shows that each byte is captured at the opening edge of its slot and not sampled later. Directed frames then hold the inputs at 0x00, 0xFF and 0xA5. These tell a wrong slot assignment or bit order apart from a correct one, since all-ones data would otherwise hide an idle-fill error. The multiframe length is set to an odd number of frames, so a marker frame can fall on an odd frame. That separates the alignment-word parity from the multiframe counter, and it also exercises the counter's wrap.

// File: rtl/e1_mux_pkg.sv
package e1_mux_pkg;
  localparam int unsigned SLOT_W  = 5;
  localparam int unsigned BIT_W   = 3;
  localparam logic [7:0] ALIGN_WORD    = 8'h9B;
  localparam logic [7:0] NONALIGN_WORD = 8'hDF;
  localparam logic [7:0] IDLE_FILL     = 8'hFF;
  localparam logic [7:0] MARK_ON       = 8'hFF;
  localparam logic [7:0] MARK_OFF      = 8'h00;
  localparam logic [SLOT_W-1:0] SIG_SLOT  = 5'd16;
  localparam logic [SLOT_W-1:0] MARK_SLOT = 5'd17;

  typedef enum logic [2:0] {
    SK_ALIGN, SK_VOICE, SK_SIG, SK_MARK, SK_IDLE
  } slot_kind_e;

  function automatic slot_kind_e kind_of(logic [SLOT_W-1:0] s, int unsigned nvoice);
    if (s == '0)                                  return SK_ALIGN;
    else if (int'(s) <= int'(nvoice))             return SK_VOICE;
    else if (s == SIG_SLOT)                       return SK_SIG;
    else if (s == MARK_SLOT)                      return SK_MARK;
    else                                          return SK_IDLE;
  endfunction
endpackage

// File: rtl/e1_frame_counter.sv
module e1_frame_counter
  import e1_mux_pkg::*;
#(
  parameter int unsigned MF_FRAMES = 2560,
  localparam int unsigned FW = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [BIT_W-1:0]  bit_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              mark_q,
  output logic              load,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic              odd_nxt,
  output logic              mark_nxt
);
  logic [FW-1:0]     frame_q, frame_d;
  logic [BIT_W-1:0]  bit_d;
  logic [SLOT_W-1:0] slot_d;
  logic              odd_q, odd_d;
  logic              slot_end, frame_end, mf_wrap;

  always_comb begin
    slot_end  = (bit_q == 3'd7);
    frame_end = slot_end && (slot_q == 5'd31);
    mf_wrap   = (frame_q == FW'(MF_FRAMES - 1));
    bit_d     = bit_q + 3'd1;
    slot_d    = slot_end ? slot_q + 5'd1 : slot_q;
    frame_d   = frame_q;
    odd_d     = odd_q;
    if (frame_end) begin
      frame_d = mf_wrap ? '0 : frame_q + FW'(1);
      odd_d   = ~odd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      slot_q  <= '0;
      frame_q <= '0;
      odd_q   <= 1'b0;
    end else begin
      bit_q   <= bit_d;
      slot_q  <= slot_d;
      frame_q <= frame_d;
      odd_q   <= odd_d;
    end
  end

  assign mark_q   = (frame_q == '0);
  assign load     = slot_end;
  assign slot_nxt = slot_d;
  assign odd_nxt  = odd_d;
  assign mark_nxt = (frame_d == '0);

  assert_frame_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frame_q) < int'(MF_FRAMES));
  assert_mf_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && mf_wrap) |=> (frame_q == '0));
  assert_parity_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (odd_q != $past(odd_q)));
  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (slot_q == '0 && bit_q == '0));
endmodule

// File: rtl/e1_slot_select.sv
module e1_slot_select
  import e1_mux_pkg::*;
#(
  parameter int unsigned NUM_VOICE = 8
) (
  input  logic [SLOT_W-1:0]      slot,
  input  logic                   odd,
  input  logic                   mark,
  input  logic [8*NUM_VOICE-1:0] voice_bytes,
  input  logic [7:0]             sig_byte,
  output logic [7:0]             slot_byte
);
  logic [7:0] voice_sel;
  slot_kind_e kind;

  always_comb begin
    voice_sel = '0;
    for (int k = 0; k < int'(NUM_VOICE); k++) begin
      if (slot == SLOT_W'(k + 1)) voice_sel = voice_bytes[8*k +: 8];
    end
  end

  always_comb begin
    kind = kind_of(slot, NUM_VOICE);
    unique case (kind)
      SK_ALIGN: slot_byte = odd ? NONALIGN_WORD : ALIGN_WORD;
      SK_VOICE: slot_byte = voice_sel;
      SK_SIG:   slot_byte = sig_byte;
      SK_MARK:  slot_byte = mark ? MARK_ON : MARK_OFF;
      default:  slot_byte = IDLE_FILL;
    endcase
  end
endmodule

// File: rtl/e1_tx_shifter.sv
module e1_tx_shifter
  import e1_mux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  output logic       tx_bit
);
  logic [7:0] shreg_q, shreg_d;

  always_comb begin
    if (load) shreg_d = load_byte;
    else      shreg_d = {shreg_q[6:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= ALIGN_WORD;
    else        shreg_q <= shreg_d;
  end

  assign tx_bit = shreg_q[7];

  assert_msb_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (shreg_q[7] == $past(shreg_q[6])));
  assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (shreg_q == $past(load_byte)));
endmodule

// File: rtl/e1_slot_mux.sv
module e1_slot_mux
  import e1_mux_pkg::*;
#(
  parameter int unsigned NUM_VOICE = 8,
  parameter int unsigned MF_FRAMES = 2560
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [8*NUM_VOICE-1:0] voice_bytes,
  input  logic [7:0]             sig_byte,
  output logic                   tx_bit,
  output logic                   frame_start,
  output logic                   mframe_start
);
  logic [BIT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] slot_q, slot_nxt;
  logic              mark_q, load, odd_nxt, mark_nxt;
  logic [7:0]        next_byte;

  e1_frame_counter #(.MF_FRAMES(MF_FRAMES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bit_q(bit_q), .slot_q(slot_q), .mark_q(mark_q),
    .load(load), .slot_nxt(slot_nxt), .odd_nxt(odd_nxt), .mark_nxt(mark_nxt)
  );

  e1_slot_select #(.NUM_VOICE(NUM_VOICE)) u_sel (
    .slot(slot_nxt), .odd(odd_nxt), .mark(mark_nxt),
    .voice_bytes(voice_bytes), .sig_byte(sig_byte), .slot_byte(next_byte)
  );

  e1_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(next_byte), .tx_bit(tx_bit)
  );

  assign frame_start  = (slot_q == '0) && (bit_q == '0);
  assign mframe_start = frame_start && mark_q;

  assert_mstrobe_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mframe_start |-> frame_start);
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: tb/tb_e1_slot_mux.sv
module tb_e1_slot_mux;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int MF = 5;
  localparam int FRAMES = 12;

  logic clk, rst_n;
  logic [8*NV-1:0] voice_bytes;
  logic [7:0] sig_byte;
  logic tx_bit, frame_start, mframe_start;

  int checks = 0, errors = 0;
  bit done = 0;

  e1_slot_mux #(.NUM_VOICE(NV), .MF_FRAMES(MF)) dut (
    .clk(clk), .rst_n(rst_n), .voice_bytes(voice_bytes), .sig_byte(sig_byte),
    .tx_bit(tx_bit), .frame_start(frame_start), .mframe_start(mframe_start)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [7:0] exp_byte(int slot, bit odd, bit mark,
                                          logic [8*NV-1:0] v, logic [7:0] s);
    if (slot == 0) return odd ? 8'hDF : 8'h9B;
    if (slot >= 1 && slot <= NV) return v[8*(slot-1) +: 8];
    if (slot == 16) return s;
    if (slot == 17) return mark ? 8'hFF : 8'h00;
    return 8'hFF;
  endfunction

  function automatic string req_of(int slot);
    if (slot == 0) return "R3";
    if (slot >= 1 && slot <= NV) return "R4/R10";
    if (slot == 16) return "R5/R10";
    if (slot == 17) return "R6";
    return "R8";
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(int frame);
    case (frame)
      3: begin voice_bytes = '0; sig_byte = 8'h00; end
      4: begin voice_bytes = '1; sig_byte = 8'hFF; end
      6: begin voice_bytes = {NV{8'hA5}}; sig_byte = 8'hA5; end
      default: begin
        for (int k = 0; k < NV; k++) voice_bytes[8*k +: 8] = 8'($urandom);
        sig_byte = 8'($urandom);
      end
    endcase
  endtask

  initial begin
    logic [8*NV-1:0] pv;
    logic [7:0] ps, eb;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    voice_bytes = '0;
    sig_byte = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 frame_start", {7'd0, frame_start}, 8'd1);
    chk("R1 mframe_start", {7'd0, mframe_start}, 8'd1);
    chk("R1 tx_bit", {7'd0, tx_bit}, 8'd1);
    rst_n = 1'b1;
    #1;
    pv = voice_bytes; ps = sig_byte; eb = 8'h9B;
    for (int n = 0; n < FRAMES*256; n++) begin
      int b, s, f;
      bit odd, mark;
      b = n % 8; s = (n / 8) % 32; f = n / 256;
      odd = f[0]; mark = (f % MF) == 0;
      if (b == 0) eb = exp_byte(s, odd, mark, pv, ps);
      // R9: MSB first, R3..R8 by slot
      chk({req_of(s), " R9"}, {7'd0, tx_bit}, {7'd0, eb[7-b]});
      chk("R2 frame_start", {7'd0, frame_start}, {7'd0, (s == 0 && b == 0)});
      chk("R7 mframe_start", {7'd0, mframe_start}, {7'd0, (s == 0 && b == 0 && mark)});
      drive(f);
      pv = voice_bytes; ps = sig_byte;
      @(negedge clk);
      #1;
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule